// File: doc/BRIEF.md
# Threshold Event Interrupt Generator

This block monitors three signed acceleration-style samples (X, Y, Z) that arrive together with a valid strobe, and raises an interrupt when configured threshold events hold. For every axis, a high event (magnitude above a programmable threshold) and a low event (magnitude below it) can be enabled on their own. The enabled events are combined either with OR (any one suffices) or with AND (all of them at once). The combined condition must persist over a programmable number of consecutive samples before it is recognized.

A status view reports the interrupt-active bit and one flag per axis and direction. In follow mode the status tracks the qualified condition on every sample. In latch mode the status holds, and new events are added to it, until a read of an acknowledge location clears it. The bus logic in front of the block turns that read into a one-cycle `ack_rd` strobe. The data returned by that read carries no meaning.

Top module: `axis_event_irq`

## Requirements
- R1: Comparisons use the sample magnitude |s| as an unsigned SAMPLE_W-bit value against the unsigned threshold `cfg_thresh`. A high event needs |s| > threshold. A low event needs |s| < threshold. Equality produces neither. Flag bit 2a is the high event and bit 2a+1 is the low event of axis a, with X=0, Y=1, Z=2.
- R2: An event whose enable bit is clear never sets its flag and never contributes to the combined condition.
- R3: With `cfg_and`=0, the condition is true when any enabled event is true.
- R4: With `cfg_and`=1, the condition is true only when every enabled event is true on the same sample.
- R5: With no event enabled, the interrupt never asserts, in either combination mode.
- R6: With duration value D, the event is recognized on the sample at which the run of consecutive true conditions reaches D+1. D=0 means the first true sample is recognized. A false sample restarts the run. The run counter saturates, so a run longer than 2^DUR_W stays recognized.
- R7: With `cfg_latch`=0, each valid sample sets `src_active` to the recognized state and sets `src_flags` to the true enabled events, or to zero when the sample is not recognized. Outputs change one clock after the valid sample and do not change without one.
- R8: With `cfg_latch`=1, `src_active` and `src_flags` hold once set. Further recognized samples OR their flags into the held value. Unrecognized samples change nothing.
- R9: In latch mode an `ack_rd` pulse clears the status one clock later. If a recognized sample arrives in the same cycle, the status afterwards shows only that sample's flags. With `cfg_latch`=0, `ack_rd` has no effect.
- R10: `irq` is always equal to `src_active`, and `src_active` is 1 exactly when some flag is set.
- R11: After reset, `irq`, `src_active` and `src_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | Marks a new sample triple |
| smp_x | input | SAMPLE_W | Signed X sample |
| smp_y | input | SAMPLE_W | Signed Y sample |
| smp_z | input | SAMPLE_W | Signed Z sample |
| cfg_hi_en | input | 3 | High-event enables, bit a = axis a |
| cfg_lo_en | input | 3 | Low-event enables, bit a = axis a |
| cfg_and | input | 1 | 1: AND combination, 0: OR combination |
| cfg_latch | input | 1 | 1: latch mode, 0: follow mode |
| cfg_thresh | input | SAMPLE_W | Unsigned magnitude threshold |
| cfg_dur | input | DUR_W | Minimum duration value D |
| ack_rd | input | 1 | Strobe for a read of the acknowledge location |
| irq | output | 1 | Interrupt output |
| src_active | output | 1 | Interrupt-active status bit |
| src_flags | output | 6 | Per axis and direction event flags |

## Verification
The bench builds the block with SAMPLE_W=6 and DUR_W=3. Both values are small enough that every signed sample value, including the most negative one whose magnitude needs the full width, is swept against several thresholds on each axis. All 64 high/low enable combinations are run under both combination modes. The 3-bit duration field also lets a run of more than eight samples reach the counter's saturation point, where a wrapping counter would drop the event.

// File: rtl/aei_pkg.sv
package aei_pkg;
  localparam int NUM_AXES = 3;
  localparam int FLAG_W   = 2 * NUM_AXES;

  typedef enum logic {
    COMB_OR  = 1'b0,
    COMB_AND = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/aei_axis_cmp.sv
module aei_axis_cmp #(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic                hi_en,
  input  logic                lo_en,
  output logic                hi_evt,
  output logic                lo_evt
);
  logic [SAMPLE_W-1:0] mag;

  // two's complement magnitude; the most negative value maps onto 2^(W-1)
  always_comb begin
    if (smp[SAMPLE_W-1]) mag = ~smp + 1'b1;
    else                 mag = smp;
  end

  assign hi_evt = hi_en && (mag > thresh);
  assign lo_evt = lo_en && (mag < thresh);
endmodule

// File: rtl/aei_combine.sv
module aei_combine
  import aei_pkg::*;
(
  input  logic [NUM_AXES-1:0] hi_evt,
  input  logic [NUM_AXES-1:0] lo_evt,
  input  logic [NUM_AXES-1:0] hi_en,
  input  logic [NUM_AXES-1:0] lo_en,
  input  comb_mode_e          mode,
  output logic                cond,
  output logic [FLAG_W-1:0]   ev_flags
);
  logic [FLAG_W-1:0] en_all;
  logic              any_en;
  logic              or_hit;
  logic              and_hit;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_pack
    assign ev_flags[2*a]   = hi_evt[a];
    assign ev_flags[2*a+1] = lo_evt[a];
    assign en_all[2*a]     = hi_en[a];
    assign en_all[2*a+1]   = lo_en[a];
  end

  assign any_en  = |en_all;
  assign or_hit  = |ev_flags;
  assign and_hit = any_en && (&(ev_flags | ~en_all));

  always_comb begin
    case (mode)
      COMB_AND: cond = and_hit;
      default:  cond = or_hit;
    endcase
  end
endmodule

// File: rtl/aei_dwell.sv
module aei_dwell #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             cond,
  input  logic [DUR_W-1:0] dur,
  output logic             qual
);
  localparam logic [DUR_W-1:0] CNT_MAX = '1;

  logic [DUR_W-1:0] run_q;
  logic [DUR_W-1:0] run_d;
  logic             run_en;

  // run_q counts earlier consecutive true samples, so the run is run_q+1
  assign qual   = cond && (run_q >= dur);
  assign run_en = valid;

  always_comb begin
    if (!cond)                run_d = '0;
    else if (run_q == CNT_MAX) run_d = run_q;
    else                      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end
endmodule

// File: rtl/aei_status.sv
module aei_status
  import aei_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              qual,
  input  logic [FLAG_W-1:0] ev_flags,
  input  logic              latch_mode,
  input  logic              ack,
  output logic              active,
  output logic [FLAG_W-1:0] flags
);
  logic              active_q, active_d;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              upd_en;
  logic              base_act;
  logic [FLAG_W-1:0] base_flags;
  logic              hit;

  assign hit = valid && qual;

  always_comb begin
    base_act   = ack ? 1'b0 : active_q;
    base_flags = ack ? '0   : flags_q;
    if (latch_mode) begin
      upd_en   = valid || ack;
      active_d = base_act || hit;
      flags_d  = base_flags | (hit ? ev_flags : '0);
    end else begin
      upd_en   = valid;
      active_d = qual;
      flags_d  = qual ? ev_flags : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      flags_q  <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      flags_q  <= flags_d;
    end
  end

  assign active = active_q;
  assign flags  = flags_q;
endmodule

// File: rtl/axis_event_irq.sv
module axis_event_irq
  import aei_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_x,
  input  logic [SAMPLE_W-1:0] smp_y,
  input  logic [SAMPLE_W-1:0] smp_z,
  input  logic [2:0]          cfg_hi_en,
  input  logic [2:0]          cfg_lo_en,
  input  logic                cfg_and,
  input  logic                cfg_latch,
  input  logic [SAMPLE_W-1:0] cfg_thresh,
  input  logic [DUR_W-1:0]    cfg_dur,
  input  logic                ack_rd,
  output logic                irq,
  output logic                src_active,
  output logic [5:0]          src_flags
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [SAMPLE_W-1:0] smp_arr [NUM_AXES];
  logic [NUM_AXES-1:0] hi_evt;
  logic [NUM_AXES-1:0] lo_evt;
  logic [FLAG_W-1:0]   ev_flags;
  logic                cond;
  logic                qual;
  comb_mode_e          mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign smp_arr[0] = smp_x;
  assign smp_arr[1] = smp_y;
  assign smp_arr[2] = smp_z;
  assign mode = cfg_and ? COMB_AND : COMB_OR;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    aei_axis_cmp #(.SAMPLE_W(SAMPLE_W)) i_cmp (
      .smp    (smp_arr[a]),
      .thresh (cfg_thresh),
      .hi_en  (cfg_hi_en[a]),
      .lo_en  (cfg_lo_en[a]),
      .hi_evt (hi_evt[a]),
      .lo_evt (lo_evt[a])
    );
  end

  aei_combine i_comb (
    .hi_evt   (hi_evt),
    .lo_evt   (lo_evt),
    .hi_en    (cfg_hi_en),
    .lo_en    (cfg_lo_en),
    .mode     (mode),
    .cond     (cond),
    .ev_flags (ev_flags)
  );

  aei_dwell #(.DUR_W(DUR_W)) i_dwell (
    .clk   (clk),
    .rst_n (rst_int_n),
    .valid (smp_valid),
    .cond  (cond),
    .dur   (cfg_dur),
    .qual  (qual)
  );

  aei_status i_status (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .valid      (smp_valid),
    .qual       (qual),
    .ev_flags   (ev_flags),
    .latch_mode (cfg_latch),
    .ack        (ack_rd),
    .active     (src_active),
    .flags      (src_flags)
  );

  assign irq = src_active;
endmodule

// File: rtl/aei_checker.sv
module aei_checker #(
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic [2:0]          cfg_hi_en,
  input logic [2:0]          cfg_lo_en,
  input logic                cfg_latch,
  input logic                ack_rd,
  input logic                irq,
  input logic                src_active,
  input logic [5:0]          src_flags
);
  AST_HOLD_WITHOUT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !ack_rd) |=> ($stable(src_flags) && $stable(src_active))); // R7

  AST_ACTIVE_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    src_active == (src_flags != 6'd0)); // R10

  AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_latch && smp_valid && cfg_hi_en == 3'd0 && cfg_lo_en == 3'd0) |=> !irq); // R5

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch && src_active && !ack_rd) |=> src_active); // R8

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch && ack_rd && !smp_valid) |=> (!src_active && src_flags == 6'd0)); // R9
endmodule

bind axis_event_irq aei_checker #(.SAMPLE_W(SAMPLE_W), .DUR_W(DUR_W)) i_aei_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .cfg_hi_en  (cfg_hi_en),
  .cfg_lo_en  (cfg_lo_en),
  .cfg_latch  (cfg_latch),
  .ack_rd     (ack_rd),
  .irq        (irq),
  .src_active (src_active),
  .src_flags  (src_flags)
);

// File: tb/test_axis_event_irq.sv
module test_axis_event_irq;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 6;
  localparam int DW = 3;

  logic          clk;
  logic          rst_n;
  logic          smp_valid;
  logic [SW-1:0] smp_x, smp_y, smp_z;
  logic [2:0]    cfg_hi_en, cfg_lo_en;
  logic          cfg_and, cfg_latch;
  logic [SW-1:0] cfg_thresh;
  logic [DW-1:0] cfg_dur;
  logic          ack_rd;
  logic          irq, src_active;
  logic [5:0]    src_flags;

  int n_checks = 0;
  int n_fail   = 0;

  axis_event_irq #(.SAMPLE_W(SW), .DUR_W(DW)) i_axis_event_irq (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .cfg_hi_en(cfg_hi_en), .cfg_lo_en(cfg_lo_en), .cfg_and(cfg_and),
    .cfg_latch(cfg_latch), .cfg_thresh(cfg_thresh), .cfg_dur(cfg_dur),
    .ack_rd(ack_rd), .irq(irq), .src_active(src_active), .src_flags(src_flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model(input int sx, input int sy, input int sz,
                                input logic [2:0] he, input logic [2:0] le,
                                input logic am, input int thr,
                                output logic [5:0] f, output logic act);
    int  s [3];
    logic [5:0] en;
    logic any, all_ok;
    s[0] = sx; s[1] = sy; s[2] = sz;
    f = '0; en = '0;
    for (int a = 0; a < 3; a++) begin
      int m;
      m = (s[a] < 0) ? -s[a] : s[a];
      en[2*a] = he[a]; en[2*a+1] = le[a];
      f[2*a]   = he[a] && (m > thr);
      f[2*a+1] = le[a] && (m < thr);
    end
    any = (en != 0);
    all_ok = any && ((f | ~en) == 6'h3f);
    act = am ? all_ok : (f != 0);
    if (!act) f = '0;
  endfunction

  task automatic check(input string req, input logic [5:0] ef, input logic ea);
    n_checks++;
    if (src_flags !== ef || src_active !== ea || irq !== ea) begin
      n_fail++;
      $display("FAIL %s: flags=%b active=%b irq=%b expected flags=%b active=%b",
               req, src_flags, src_active, irq, ef, ea);
    end
  endtask

  task automatic sample(input int sx, input int sy, input int sz, input logic ack);
    @(negedge clk);
    smp_x = SW'(sx); smp_y = SW'(sy); smp_z = SW'(sz);
    smp_valid = 1'b1; ack_rd = ack;
    @(negedge clk);
    smp_valid = 1'b0; ack_rd = 1'b0;
  endtask

  task automatic ack_only();
    @(negedge clk);
    ack_rd = 1'b1;
    @(negedge clk);
    ack_rd = 1'b0;
  endtask

  task automatic flush();
    cfg_latch = 1'b0; cfg_hi_en = '0; cfg_lo_en = '0;
    sample(0, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [5:0] ef;
    logic ea;
    rst_n = 1'b0; smp_valid = 1'b0; ack_rd = 1'b0;
    smp_x = '0; smp_y = '0; smp_z = '0;
    cfg_hi_en = '0; cfg_lo_en = '0; cfg_and = 1'b0; cfg_latch = 1'b0;
    cfg_thresh = '0; cfg_dur = '0;
    repeat (3) @(negedge clk);
    check("R11 reset", 6'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after release", 6'd0, 1'b0);

    // R1: every sample value on every axis against several thresholds
    for (int a = 0; a < 3; a++) begin
      for (int ti = 0; ti < 5; ti++) begin
        int thr;
        thr = (ti == 0) ? 0 : (ti == 1) ? 1 : (ti == 2) ? 17 : (ti == 3) ? 32 : 63;
        cfg_thresh = SW'(thr); cfg_and = 1'b0; cfg_dur = '0;
        cfg_hi_en = 3'(1 << a); cfg_lo_en = 3'(1 << a);
        for (int v = -32; v < 32; v++) begin
          int s [3];
          s[0] = 0; s[1] = 0; s[2] = 0; s[a] = v;
          sample(s[0], s[1], s[2], 1'b0);
          model(s[0], s[1], s[2], cfg_hi_en, cfg_lo_en, 1'b0, thr, ef, ea);
          check("R1 magnitude compare", ef, ea);
        end
      end
    end

    // R2 R3 R4 R5: all enable combinations under both modes
    cfg_thresh = SW'(10); cfg_dur = '0;
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 64; e++) begin
        cfg_and = m[0];
        cfg_hi_en = e[2:0]; cfg_lo_en = e[5:3];
        for (int k = 0; k < 6; k++) begin
          int sx, sy, sz;
          sx = ((k*23 + 5) % 64) - 32;
          sy = ((k*11 + e) % 24) - 12;
          sz = ((k*7 + 3*e) % 30) - 15;
          sample(sx, sy, sz, 1'b0);
          model(sx, sy, sz, cfg_hi_en, cfg_lo_en, cfg_and, 10, ef, ea);
          if (e == 0) check("R5 no enables", ef, ea);
          else if (m == 1) check("R4 AND combine / R2 disabled", ef, ea);
          else check("R3 OR combine / R2 disabled", ef, ea);
        end
      end
    end

    // R6: duration qualification, restart and saturation
    flush();
    cfg_and = 1'b0; cfg_thresh = SW'(10); cfg_hi_en = 3'b001; cfg_dur = DW'(3);
    for (int i = 1; i <= 4; i++) begin
      sample(20, 0, 0, 1'b0);
      check("R6 duration 3", (i >= 4) ? 6'b000001 : 6'd0, i >= 4);
    end
    sample(0, 0, 0, 1'b0);
    check("R6 run broken", 6'd0, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      sample(-25, 0, 0, 1'b0);
      check("R6 restart", (i >= 4) ? 6'b000001 : 6'd0, i >= 4);
    end
    sample(0, 0, 0, 1'b0);
    cfg_dur = DW'(7);
    for (int i = 1; i <= 12; i++) begin
      sample(20, 0, 0, 1'b0);
      check("R6 saturation", (i >= 8) ? 6'b000001 : 6'd0, i >= 8);
    end

    // R8 R9: latch mode
    flush();
    cfg_dur = '0; cfg_thresh = SW'(10); cfg_and = 1'b0;
    cfg_hi_en = 3'b001; cfg_lo_en = 3'b010; cfg_latch = 1'b1;
    sample(20, 15, 0, 1'b0);
    check("R8 latch set", 6'b000001, 1'b1);
    sample(0, 15, 0, 1'b0);
    check("R8 latch hold", 6'b000001, 1'b1);
    sample(0, 3, 0, 1'b0);
    check("R8 latch accumulate", 6'b001001, 1'b1);
    ack_only();
    check("R9 ack clears", 6'd0, 1'b0);
    sample(20, 15, 0, 1'b1);
    check("R9 ack with new event", 6'b000001, 1'b1);
    ack_only();
    check("R9 ack clears again", 6'd0, 1'b0);
    sample(0, 15, 0, 1'b0);
    check("R8 no event stays clear", 6'd0, 1'b0);

    // R7: follow mode and ignored ack
    cfg_latch = 1'b0;
    sample(20, 15, 0, 1'b0);
    check("R7 follow set", 6'b000001, 1'b1);
    ack_only();
    check("R9 ack ignored in follow", 6'b000001, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 no sample no change", 6'b000001, 1'b1);
    sample(0, 15, 0, 1'b0);
    check("R7 follow clear", 6'd0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule